// File: doc/BRIEF.md
# Card Bus Clock Divider with Operation Watchdog

This block generates the bus clock for a multi-slot memory-card host. A fast internal clock is divided into a card clock. Two separately programmed counts set how many internal cycles the high phase lasts and how many the low phase lasts. Software computes each count as the ceiling of the internal frequency over twice the card frequency. Equal counts give a near-even duty cycle, and a slow start-up rate (about 400 kHz) comes from the reset counts. The card clock reaches only the one slot that is selected and whose bus is released from reset.

A settings word carries the slot selection, a high-speed timing bit, a bus-width code, a power class and both phase counts. A write latches the word as pending and raises a busy flag. The pending word becomes active only when a full low phase ends, which is the instant the clock rises. At that point busy clears, so software polls busy to learn that the change has taken effect.

A watchdog counts card-clock rising edges while an operation runs. An operation start arms it and clears the count and the flag. A rising edge during data activity restarts the count, and an operation-done pulse disarms it. When the count reaches the programmed limit, a sticky timeout flag is set and the running indication drops.

Top module: `cardclk_gen`

## Requirements
- R1: After reset all slot clocks and bus-release outputs are 0, busy, wd_running and wd_timeout are 0, act_width is 0, act_hs is 0, act_slot is 0, act_power is 10, and the slot clock uses the default counts DEF_HI high and DEF_LO low (125 each).
- R2: The selected slot clock stays high for exactly the active high count of internal cycles and low for exactly the active low count, and the two counts act independently.
- R3: A phase count of 0 behaves as a count of 1.
- R4: The settings word has lo in bits 7:0, hi in bits 15:8, power class in bits 19:16, width code in bits 21:20, high-speed in bit 22 and slot in bits 24:23. A write sets busy in the cycle after the write, and busy stays set until the word is applied.
- R5: A pending word is applied only where a full low phase ends. Busy clears, and act_slot, act_hs, act_width and act_power change, in the same cycle that the clock rises.
- R6: Width code 0 (1 bit), 1 (4 bit) and 2 (8 bit) are applied as written, and the reserved code 3 is applied as 0.
- R7: Bit i of the enable word drives bus_rst_n[i] high. slot_clk[i] toggles only while slot i is the active slot and is enabled, and every other slot clock is held at 0.
- R8: op_start arms the watchdog (wd_running 1) and clears its count and flag. Each rising card-clock edge without data activity counts one, and the edge that brings the count to the limit sets wd_timeout and clears wd_running.
- R9: A rising card-clock edge with data_act high restarts the count from zero.
- R10: wd_timeout stays set until the next op_start. op_done disarms the watchdog without setting the flag.
- R11: The limit can be written through wd_wr/wd_limit_in, its reset value is DEF_WDOG, and a limit of 0 or 1 expires on the first counted edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Settings word write strobe |
| cfg_word | input | 25 | Settings word (layout in R4) |
| en_wr | input | 1 | Slot enable write strobe |
| en_word | input | 4 | Per-slot bus enable bits |
| wd_wr | input | 1 | Watchdog limit write strobe |
| wd_limit_in | input | 20 | Watchdog limit in card-clock edges |
| op_start | input | 1 | Operation issued: arm watchdog |
| op_done | input | 1 | Operation finished: disarm watchdog |
| data_act | input | 1 | Data or response activity on the bus |
| busy | output | 1 | Settings change pending |
| act_slot | output | 2 | Active slot |
| act_hs | output | 1 | Active high-speed timing bit |
| act_width | output | 2 | Active bus width code |
| act_power | output | 4 | Active power class |
| slot_clk | output | 4 | Card clock per slot |
| bus_rst_n | output | 4 | Per-slot bus release (0 holds in reset) |
| wd_running | output | 1 | Watchdog armed |
| wd_timeout | output | 1 | Sticky timeout flag |

## Verification
The bound checker watches several properties on every cycle. It checks that busy follows each write, that busy falls and the active settings change only on a clock rise, and that at most one slot clock is high. It also checks that the reserved width code never becomes active, that the timeout flag holds until a new start, and that the watchdog is never armed and expired at once. Exact phase lengths, the treatment of zero counts, the slot-enable gating, and the number of edges before expiry with and without data activity are properties of whole waveforms, so only the bench scenarios can show them.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
  localparam int CNT_W  = 8;
  localparam int SLOT_W = 2;
  localparam int PWR_W  = 4;
  localparam int BW_W   = 2;
  localparam int NSLOT  = 1 << SLOT_W;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic              hs;
    logic [BW_W-1:0]   bw;
    logic [PWR_W-1:0]  pwr;
    logic [CNT_W-1:0]  hi;
    logic [CNT_W-1:0]  lo;
  } cc_set_t;

  localparam int SET_W = $bits(cc_set_t);

  function automatic logic [CNT_W-1:0] eff_cnt(input logic [CNT_W-1:0] c);
    return (c == '0) ? CNT_W'(1) : c;
  endfunction
endpackage

// File: rtl/cardclk_div.sv
module cardclk_div
  import cardclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] lo_cnt,
  output logic             phase,
  output logic             low_end
);
  logic [CNT_W-1:0] cnt_q, cnt_d, len;
  logic             phase_d, last;

  always_comb begin
    len     = phase ? eff_cnt(hi_cnt) : eff_cnt(lo_cnt);
    last    = (cnt_q + CNT_W'(1)) == len;
    low_end = last & ~phase;
    phase_d = last ? ~phase : phase;
    cnt_d   = last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      phase <= phase_d;
    end
  end
endmodule

// File: rtl/cardclk_cfg.sv
module cardclk_cfg
  import cardclk_pkg::*;
#(
  parameter int DEF_HI  = 125,
  parameter int DEF_LO  = 125,
  parameter int DEF_PWR = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  cc_set_t          word,
  input  logic             en_wr,
  input  logic [NSLOT-1:0] en_word,
  input  logic             apply,
  output logic             busy,
  output cc_set_t          act,
  output logic [NSLOT-1:0] slot_en
);
  localparam cc_set_t RST_SET = '{slot: '0, hs: 1'b0, bw: '0,
                                  pwr: PWR_W'(DEF_PWR),
                                  hi: CNT_W'(DEF_HI), lo: CNT_W'(DEF_LO)};

  cc_set_t          pend_q, pend_d, act_d;
  logic             busy_d;
  logic [NSLOT-1:0] en_d;

  always_comb begin
    pend_d = wr ? word : pend_q;
    busy_d = wr | (busy & ~apply);
    en_d   = en_wr ? en_word : slot_en;
    act_d  = act;
    if (apply && busy) begin
      act_d = pend_q;
      if (pend_q.bw > BW_W'(2)) act_d.bw = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= RST_SET;
      act     <= RST_SET;
      busy    <= 1'b0;
      slot_en <= '0;
    end else begin
      pend_q  <= pend_d;
      act     <= act_d;
      busy    <= busy_d;
      slot_en <= en_d;
    end
  end
endmodule

// File: rtl/cardclk_wdog.sv
module cardclk_wdog #(
  parameter int WD_W     = 20,
  parameter int DEF_WDOG = 340000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [WD_W-1:0] limit_in,
  input  logic            start,
  input  logic            done,
  input  logic            act,
  input  logic            rise,
  output logic            running,
  output logic            timeout
);
  logic [WD_W-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic [WD_W:0]   nxt;
  logic            run_d, to_d;

  always_comb begin
    nxt   = {1'b0, cnt_q} + (WD_W+1)'(1);
    lim_d = wr ? limit_in : lim_q;
    cnt_d = cnt_q;
    run_d = running;
    to_d  = timeout;
    if (start) begin
      run_d = 1'b1;
      cnt_d = '0;
      to_d  = 1'b0;
    end else if (done) begin
      run_d = 1'b0;
    end else if (running && rise) begin
      if (act) begin
        cnt_d = '0;
      end else if (nxt >= {1'b0, lim_q}) begin
        to_d  = 1'b1;
        run_d = 1'b0;
      end else begin
        cnt_d = nxt[WD_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      lim_q   <= WD_W'(DEF_WDOG);
      running <= 1'b0;
      timeout <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      lim_q   <= lim_d;
      running <= run_d;
      timeout <= to_d;
    end
  end
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
  import cardclk_pkg::*;
#(
  parameter int DEF_HI   = 125,
  parameter int DEF_LO   = 125,
  parameter int DEF_PWR  = 10,
  parameter int WD_W     = 20,
  parameter int DEF_WDOG = 340000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [SET_W-1:0]  cfg_word,
  input  logic              en_wr,
  input  logic [NSLOT-1:0]  en_word,
  input  logic              wd_wr,
  input  logic [WD_W-1:0]   wd_limit_in,
  input  logic              op_start,
  input  logic              op_done,
  input  logic              data_act,
  output logic              busy,
  output logic [SLOT_W-1:0] act_slot,
  output logic              act_hs,
  output logic [BW_W-1:0]   act_width,
  output logic [PWR_W-1:0]  act_power,
  output logic [NSLOT-1:0]  slot_clk,
  output logic [NSLOT-1:0]  bus_rst_n,
  output logic              wd_running,
  output logic              wd_timeout
);
  cc_set_t          act_q;
  logic             clk_phase, low_end;
  logic [NSLOT-1:0] slot_en;

  cardclk_div u_div (
    .clk(clk), .rst_n(rst_n), .hi_cnt(act_q.hi), .lo_cnt(act_q.lo),
    .phase(clk_phase), .low_end(low_end)
  );

  cardclk_cfg #(.DEF_HI(DEF_HI), .DEF_LO(DEF_LO), .DEF_PWR(DEF_PWR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .word(cc_set_t'(cfg_word)),
    .en_wr(en_wr), .en_word(en_word), .apply(low_end),
    .busy(busy), .act(act_q), .slot_en(slot_en)
  );

  cardclk_wdog #(.WD_W(WD_W), .DEF_WDOG(DEF_WDOG)) u_wdog (
    .clk(clk), .rst_n(rst_n), .wr(wd_wr), .limit_in(wd_limit_in),
    .start(op_start), .done(op_done), .act(data_act), .rise(low_end),
    .running(wd_running), .timeout(wd_timeout)
  );

  assign act_slot  = act_q.slot;
  assign act_hs    = act_q.hs;
  assign act_width = act_q.bw;
  assign act_power = act_q.pwr;
  assign bus_rst_n = slot_en;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign slot_clk[i] = clk_phase & slot_en[i] & (act_q.slot == SLOT_W'(i));
  end
endmodule

// File: rtl/cardclk_gen_chk.sv
module cardclk_gen_chk
  import cardclk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             busy,
  input logic             phase,
  input cc_set_t          act,
  input logic [NSLOT-1:0] slot_clk,
  input logic             op_start,
  input logic             wd_running,
  input logic             wd_timeout
);
  AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) cfg_wr |=> busy); // R4
  AST_APPLY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $rose(phase)); // R5
  AST_SET_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(act) |-> $rose(phase)); // R5
  AST_NO_RSVD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) act.bw != 2'b11); // R6
  AST_ONE_SLOT_CLK: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(slot_clk)); // R7
  AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rst_n) wd_timeout && !op_start |=> wd_timeout); // R10
  AST_RUN_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(wd_running && wd_timeout)); // R10
endmodule

bind cardclk_gen cardclk_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .busy(busy), .phase(clk_phase),
  .act(act_q), .slot_clk(slot_clk), .op_start(op_start),
  .wd_running(wd_running), .wd_timeout(wd_timeout)
);

// File: tb/cardclk_gen_bench.sv
module cardclk_gen_bench;
  import cardclk_pkg::*;

  logic clk = 1'b0;
  logic rst_n, cfg_wr, en_wr, wd_wr, op_start, op_done, data_act;
  logic [SET_W-1:0] cfg_word;
  logic [NSLOT-1:0] en_word, slot_clk, bus_rst_n;
  logic [19:0] wd_limit_in;
  logic busy, act_hs, wd_running, wd_timeout;
  logic [1:0] act_slot, act_width;
  logic [3:0] act_power;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  cardclk_gen u_cardclk_gen (.*);

  // {hi, lo, expected high length, expected low length}
  localparam int VEC [0:6][0:3] = '{'{1,1,1,1}, '{2,3,2,3}, '{5,2,5,2},
    '{0,4,1,4}, '{3,0,3,1}, '{0,0,1,1}, '{7,7,7,7}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [SET_W-1:0] mk(int s, int hs, int bw, int pw, int hi, int lo);
    logic [SET_W-1:0] w = '0;
    w[7:0] = 8'(lo); w[15:8] = 8'(hi); w[19:16] = 4'(pw);
    w[21:20] = 2'(bw); w[22] = 1'(hs); w[24:23] = 2'(s);
    return w;
  endfunction

  task automatic write_cfg(input logic [SET_W-1:0] w);
    cfg_word = w; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic measure(output int h, output int l);
    while (slot_clk[0] !== 1'b0) @(negedge clk);
    while (slot_clk[0] === 1'b0) @(negedge clk);
    h = 0; while (slot_clk[0] === 1'b1) begin h++; @(negedge clk); end
    l = 0; while (slot_clk[0] === 1'b0) begin l++; @(negedge clk); end
  endtask

  task automatic wait_rises(input int n);
    int c = 0;
    logic p = slot_clk[0];
    while (c < n) begin
      @(negedge clk);
      if (slot_clk[0] && !p) c++;
      p = slot_clk[0];
    end
  endtask

  task automatic pulse_start();
    op_start = 1'b1; @(negedge clk); op_start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int h, l, ones, rises;
    logic pc;
    logic [3:0] pp;
    rst_n = 1'b0; cfg_wr = 0; en_wr = 0; wd_wr = 0; op_start = 0; op_done = 0;
    data_act = 0; cfg_word = '0; en_word = '0; wd_limit_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 slot_clk", int'(slot_clk), 0);
    chk("R1 bus_rst_n", int'(bus_rst_n), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 timeout", int'(wd_timeout), 0);
    chk("R1 running", int'(wd_running), 0);
    chk("R1 power", int'(act_power), 10);
    chk("R1 width", int'(act_width), 0);
    chk("R1 slot", int'(act_slot), 0);
    en_word = 4'b0001; en_wr = 1'b1; @(negedge clk); en_wr = 1'b0;
    chk("R7 release", int'(bus_rst_n), 1);
    measure(h, l);
    chk("R1 default hi", h, 125);
    chk("R1 default lo", l, 125);

    // R2 R3 vector walk
    for (int i = 0; i < 7; i++) begin
      write_cfg(mk(0, 0, 0, 10, VEC[i][0], VEC[i][1]));
      chk("R4 busy set", int'(busy), 1);
      wait_idle();
      measure(h, l);
      chk((VEC[i][0] == 0) ? "R3 hi" : "R2 hi", h, VEC[i][2]);
      chk((VEC[i][1] == 0) ? "R3 lo" : "R2 lo", l, VEC[i][3]);
    end

    // R5 apply at end of low phase (hi=lo=7 active)
    write_cfg(mk(0, 1, 2, 6, 3, 3));
    chk("R4 busy held", int'(busy), 1);
    do begin pc = slot_clk[0]; pp = act_power; @(negedge clk); end while (busy);
    chk("R5 clk rises", int'({pc, slot_clk[0]}), 1);
    chk("R5 old power", int'(pp), 6 == 6 ? 10 : 0);
    chk("R5 new power", int'(act_power), 6);
    chk("R5 hs", int'(act_hs), 1);
    chk("R6 width 2", int'(act_width), 2);

    write_cfg(mk(0, 0, 3, 10, 3, 3)); wait_idle();
    chk("R6 width 3 reserved", int'(act_width), 0);
    write_cfg(mk(0, 0, 1, 10, 3, 3)); wait_idle();
    chk("R6 width 1", int'(act_width), 1);

    // R7 slot gating
    write_cfg(mk(2, 0, 1, 10, 3, 3)); wait_idle();
    chk("R7 active slot", int'(act_slot), 2);
    ones = 0;
    repeat (20) begin @(negedge clk); ones += $countones(slot_clk); end
    chk("R7 disabled slot silent", ones, 0);
    en_word = 4'b0100; en_wr = 1'b1; @(negedge clk); en_wr = 1'b0;
    chk("R7 release slot2", int'(bus_rst_n), 4);
    rises = 0; ones = 0; pc = slot_clk[2];
    repeat (24) begin
      @(negedge clk);
      if (slot_clk[2] && !pc) rises++;
      pc = slot_clk[2];
      ones += int'(slot_clk[0]) + int'(slot_clk[1]) + int'(slot_clk[3]);
    end
    chk("R7 slot2 toggles", int'(rises > 2), 1);
    chk("R7 others low", ones, 0);
    en_word = 4'b0001; en_wr = 1'b1; @(negedge clk); en_wr = 1'b0;
    write_cfg(mk(0, 0, 0, 10, 1, 1)); wait_idle();

    // R8 watchdog expiry
    wd_limit_in = 20'd5; wd_wr = 1'b1; @(negedge clk); wd_wr = 1'b0;
    pulse_start();
    chk("R8 running", int'(wd_running), 1);
    wait_rises(4);
    chk("R8 before limit", int'(wd_timeout), 0);
    wait_rises(1);
    chk("R8 at limit", int'(wd_timeout), 1);
    chk("R10 abort", int'(wd_running), 0);
    repeat (10) @(negedge clk);
    chk("R10 sticky", int'(wd_timeout), 1);

    // R9 data activity restarts count
    data_act = 1'b1;
    pulse_start();
    chk("R10 start clears", int'(wd_timeout), 0);
    wait_rises(10);
    chk("R9 no timeout in activity", int'(wd_timeout), 0);
    chk("R9 still running", int'(wd_running), 1);
    data_act = 1'b0;
    wait_rises(4);
    chk("R9 restart before limit", int'(wd_timeout), 0);
    wait_rises(1);
    chk("R9 restart at limit", int'(wd_timeout), 1);

    // R10 op_done disarms
    pulse_start();
    wait_rises(2);
    op_done = 1'b1; @(negedge clk); op_done = 1'b0;
    wait_rises(10);
    chk("R10 done disarms", int'(wd_running), 0);
    chk("R10 no flag after done", int'(wd_timeout), 0);

    // R11 limit 0 and 3
    wd_limit_in = 20'd0; wd_wr = 1'b1; @(negedge clk); wd_wr = 1'b0;
    pulse_start();
    wait_rises(1);
    chk("R11 limit 0", int'(wd_timeout), 1);
    wd_limit_in = 20'd3; wd_wr = 1'b1; @(negedge clk); wd_wr = 1'b0;
    pulse_start();
    wait_rises(2);
    chk("R11 limit 3 early", int'(wd_timeout), 0);
    wait_rises(1);
    chk("R11 limit 3", int'(wd_timeout), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule